// File: doc/BRIEF.md
# Single-Cycle 16-Bit Load/Store Processor Core

This block is a small processor that completes one 16-bit instruction every clock cycle. Each word is fetched from a 256-word instruction store, decoded, executed in a 16-bit ALU and retired in the same cycle. Results go to an eight-entry register file or to a 256-word data store. Branches and jumps take absolute targets straight from the instruction word. Register index 7 is a constant zero. The word 0xFFFF stops the core.

The program is written through a simple write port while the synchronous reset is held. When reset is released the core runs from address 0. A two-state controller governs execution. In RUN, every instruction commits its write and advances the PC. The transition RUN -> HALT is taken on the clock edge where the fetched word is 0xFFFF. HALT is absorbing: PC and state freeze, no write commits, and only reset (any state -> RUN) leaves it. The halted flag shows HALT. Debug outputs expose the PC and all eight registers.

Instruction fields: opcode [15:13], rs [12:10], rt [9:7], rd [6:4], function [3:0], immediate [6:0] (sign-extended for arithmetic and address use), jump target [12:0].

Top module: `sc16_core`

## Requirements
- R1: While reset is asserted at a clock edge, PC, all registers and halted are cleared to zero, and the controller enters RUN.
- R2: Opcode 000 writes rd from rs and rt. function[2:0] selects the operation: 000 add, 001 subtract (rs-rt), 010 shift rs left by rt[3:0], 011 signed rs<rt gives 1 else 0, 100 AND, 101 OR, 110 bitwise NOT of rs, 111 XOR. function[3] has no effect.
- R3: Opcode 001 writes rt with rs + sext(imm). Opcode 010 writes rt with rs - sext(imm). sext extends from bit 6.
- R4: Opcode 011 stores R[rt] into data word (rs + sext(imm))[7:0] and writes no register.
- R5: Opcode 100 loads rt from data word (rs + sext(imm))[7:0].
- R6: Opcode 110 compares R[rs] and R[rt]. If they are equal, the next PC is imm[6:0] zero-extended, otherwise PC+1. It writes nothing.
- R7: Opcode 101 sets the next PC to bits [12:0] zero-extended and writes nothing.
- R8: Register 7 always reads as zero. Writes to it are dropped.
- R9: Every other instruction in RUN advances the PC by exactly 1 per clock. The instruction store is addressed by PC[7:0].
- R10: Fetching 0xFFFF takes RUN -> HALT at that edge. From then on halted is 1, and the PC and registers stay frozen until reset.
- R11: A rising edge with prog_we high writes prog_data to instruction word prog_addr.
- R12: Opcode 111 words other than 0xFFFF are no-ops that advance the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | 8 | Instruction store write address |
| prog_data | input | 16 | Instruction word to write |
| halted | output | 1 | High in HALT state |
| dbg_pc | output | 16 | Current PC |
| dbg_regs | output | 128 | Register i on bits [16*i+15:16*i] |

## Verification
On every cycle, the assertions check the following:
- The PC step after ordinary instructions.
- The jump target.
- That at most one of the jump, branch, store and register-write controls is active.
- Entry into HALT and the freezing of PC and registers inside it.
- That register 7 stays zero after a write to it.

Only the bench scenarios can show the following:
- The ALU results of each function code.
- Sign extension.
- Memory address wrap.
- Store and load round trips.
- Branch-taken versus not-taken paths.
- Reset clearing a populated register file.

// File: rtl/sc16_pkg.sv
package sc16_pkg;

    typedef enum logic [2:0] {
        OP_RTYPE = 3'b000,
        OP_ADDI  = 3'b001,
        OP_SUBI  = 3'b010,
        OP_STORE = 3'b011,
        OP_LOAD  = 3'b100,
        OP_JUMP  = 3'b101,
        OP_BEQ   = 3'b110,
        OP_EXT   = 3'b111
    } opcode_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_SHL = 3'd2,
        ALU_SLT = 3'd3,
        ALU_AND = 3'd4,
        ALU_OR  = 3'd5,
        ALU_NOT = 3'd6,
        ALU_XOR = 3'd7
    } alu_op_e;

    typedef enum logic {
        CORE_RUN  = 1'b0,
        CORE_HALT = 1'b1
    } core_state_e;

    typedef struct packed {
        logic    jump;
        logic    branch;
        logic    mem_we;
        logic    reg_we;
        logic    use_imm;
        logic    dst_rt;
        logic    load;
        logic    halt;
        alu_op_e alu_op;
    } ctrl_t;

    localparam logic [15:0] HALT_WORD = 16'hFFFF;

endpackage

// File: rtl/sc16_decode.sv
module sc16_decode
    import sc16_pkg::*;
(
    input  logic [15:0] instr,
    output ctrl_t       ctrl
);
    opcode_e op;

    always_comb begin
        op   = opcode_e'(instr[15:13]);
        ctrl = '{jump: 1'b0, branch: 1'b0, mem_we: 1'b0, reg_we: 1'b0,
                 use_imm: 1'b0, dst_rt: 1'b0, load: 1'b0, halt: 1'b0,
                 alu_op: ALU_ADD};
        unique case (op)
            OP_RTYPE: begin
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = alu_op_e'(instr[2:0]);
            end
            OP_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.dst_rt  = 1'b1;
            end
            OP_SUBI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.dst_rt  = 1'b1;
                ctrl.alu_op  = ALU_SUB;
            end
            OP_STORE: begin
                ctrl.mem_we  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OP_LOAD: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.dst_rt  = 1'b1;
                ctrl.load    = 1'b1;
            end
            OP_JUMP: ctrl.jump = 1'b1;
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_EXT: ctrl.halt = (instr == HALT_WORD);
            default: ctrl.halt = 1'b0;
        endcase
    end
endmodule

// File: rtl/sc16_alu.sv
module sc16_alu
    import sc16_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    localparam int SHW = $clog2(XLEN);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SHL: y = a << b[SHW-1:0];
            ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOT: y = ~a;
            ALU_XOR: y = a ^ b;
            default: y = '0;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/sc16_regfile.sv
module sc16_regfile #(
    parameter int XLEN = 16,
    parameter int NREG = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(NREG)-1:0]  waddr,
    input  logic [XLEN-1:0]          wdata,
    input  logic [$clog2(NREG)-1:0]  ra,
    input  logic [$clog2(NREG)-1:0]  rb,
    output logic [XLEN-1:0]          rdata_a,
    output logic [XLEN-1:0]          rdata_b,
    output logic [NREG*XLEN-1:0]     dump
);
    localparam int AW = $clog2(NREG);
    localparam logic [AW-1:0] ZERO_IDX = AW'(NREG - 1);

    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && waddr != ZERO_IDX) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (ra == ZERO_IDX) ? '0 : regs[ra];
    assign rdata_b = (rb == ZERO_IDX) ? '0 : regs[rb];

    for (genvar g = 0; g < NREG; g++) begin : g_dump
        assign dump[g*XLEN +: XLEN] = regs[g];
    end

    p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == ZERO_IDX) |=> (regs[ZERO_IDX] == '0));
endmodule

// File: rtl/sc16_core.sv
module sc16_core
    import sc16_pkg::*;
#(
    parameter int XLEN       = 16,
    parameter int NREG       = 8,
    parameter int IMEM_DEPTH = 256,
    parameter int DMEM_DEPTH = 256
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          prog_we,
    input  logic [$clog2(IMEM_DEPTH)-1:0] prog_addr,
    input  logic [15:0]                   prog_data,
    output logic                          halted,
    output logic [XLEN-1:0]               dbg_pc,
    output logic [NREG*XLEN-1:0]          dbg_regs
);
    localparam int IA  = $clog2(IMEM_DEPTH);
    localparam int DA  = $clog2(DMEM_DEPTH);
    localparam int RA  = $clog2(NREG);
    localparam int IMM = 7;
    localparam int JMP = 13;

    logic [15:0]     imem [IMEM_DEPTH];
    logic [XLEN-1:0] dmem [DMEM_DEPTH];

    core_state_e     state, state_nx;
    logic [XLEN-1:0] pc, pc_nx;
    logic [15:0]     instr;
    ctrl_t           ctrl;
    logic            run_en;

    logic [XLEN-1:0] rs_val, rt_val, imm_sx, alu_b, alu_y, wb_data, ld_data;
    logic            alu_zero, br_taken;
    logic [RA-1:0]   wb_addr;

    // instruction store: program port and fetch
    always_ff @(posedge clk) begin
        if (prog_we) imem[prog_addr] <= prog_data;
    end
    assign instr = imem[pc[IA-1:0]];

    sc16_decode u_dec (.instr(instr), .ctrl(ctrl));

    // controller: state register
    always_ff @(posedge clk) begin
        if (rst) state <= CORE_RUN;
        else     state <= state_nx;
    end

    // controller: next state and outputs
    always_comb begin
        state_nx = state;
        run_en   = 1'b0;
        halted   = 1'b0;
        unique case (state)
            CORE_RUN: begin
                run_en = !ctrl.halt;
                if (ctrl.halt) state_nx = CORE_HALT;
            end
            CORE_HALT: begin
                halted = 1'b1;
            end
            default: state_nx = CORE_RUN;
        endcase
    end

    assign imm_sx  = {{(XLEN-IMM){instr[IMM-1]}}, instr[IMM-1:0]};
    assign alu_b   = ctrl.use_imm ? imm_sx : rt_val;
    assign wb_addr = ctrl.dst_rt ? instr[9:7] : instr[6:4];
    assign ld_data = dmem[alu_y[DA-1:0]];
    assign wb_data = ctrl.load ? ld_data : alu_y;

    sc16_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk(clk), .rst(rst),
        .we(run_en && ctrl.reg_we), .waddr(wb_addr), .wdata(wb_data),
        .ra(instr[12:10]), .rb(instr[9:7]),
        .rdata_a(rs_val), .rdata_b(rt_val), .dump(dbg_regs)
    );

    sc16_alu #(.XLEN(XLEN)) u_alu (
        .a(rs_val), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .zero(alu_zero)
    );

    always_ff @(posedge clk) begin
        if (run_en && ctrl.mem_we) dmem[alu_y[DA-1:0]] <= rt_val;
    end

    // next-PC selection
    assign br_taken = ctrl.branch && alu_zero;
    always_comb begin
        if (ctrl.jump)    pc_nx = {{(XLEN-JMP){1'b0}}, instr[JMP-1:0]};
        else if (br_taken) pc_nx = {{(XLEN-IMM){1'b0}}, instr[IMM-1:0]};
        else              pc_nx = pc + XLEN'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)         pc <= '0;
        else if (run_en) pc <= pc_nx;
    end

    assign dbg_pc = pc;

    p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
        (run_en && !ctrl.jump && !br_taken) |=> dbg_pc == XLEN'($past(dbg_pc) + 1'b1));
    p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
        (run_en && ctrl.jump) |=> dbg_pc == {{(XLEN-JMP){1'b0}}, $past(instr[JMP-1:0])});
    p_ctrl_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl.jump, ctrl.branch, ctrl.mem_we, ctrl.reg_we}));
    p_halt_entry_r10: assert property (@(posedge clk) disable iff (rst)
        (!halted && ctrl.halt) |=> halted);
    p_halt_pc_r10: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(dbg_pc) && halted);
    p_halt_regs_r10: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(dbg_regs));
endmodule

// File: tb/sim_sc16_core.sv
module sim_sc16_core;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         prog_we = 1'b0;
    logic [7:0]   prog_addr = '0;
    logic [15:0]  prog_data = '0;
    logic         halted;
    logic [15:0]  dbg_pc;
    logic [127:0] dbg_regs;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] prog [256];

    always #4 clk = ~clk;

    sc16_core u0 (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .halted(halted), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
    );

    function automatic logic [15:0] xr(int i);
        return dbg_regs[i*16 +: 16];
    endfunction

    function automatic logic [15:0] r_ins(int rd, int rs, int rt, logic [3:0] fn);
        return {3'b000, 3'(rs), 3'(rt), 3'(rd), fn};
    endfunction

    function automatic logic [15:0] i_ins(logic [2:0] op, int rt, int rs, int imm);
        return {op, 3'(rs), 3'(rt), 7'(imm)};
    endfunction

    function automatic logic [15:0] j_ins(int a);
        return {3'b101, 13'(a)};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = 16'hFFFF;
    endtask

    // holds reset while writing the program through the port (R11)
    task automatic load_and_start();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 256; i++) begin
            prog_we = 1'b1; prog_addr = 8'(i); prog_data = prog[i];
            @(negedge clk);
        end
        prog_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_halt(string tag, int limit);
        for (int i = 0; i < limit && !halted; i++) @(negedge clk);
        chk(tag, 16'(halted), 16'd1);
    endtask

    task automatic t_alu_a();
        clear_prog();
        prog[0] = i_ins(3'b001, 0, 7, 13);
        prog[1] = i_ins(3'b001, 1, 7, 2);
        prog[2] = r_ins(2, 0, 1, 4'b1000);   // add with function[3] set
        prog[3] = r_ins(3, 0, 1, 4'b0001);
        prog[4] = r_ins(4, 0, 1, 4'b0010);
        prog[5] = r_ins(5, 1, 0, 4'b0011);
        prog[6] = r_ins(6, 0, 1, 4'b0100);
        load_and_start();
        run_to_halt("R10 alu_a halt", 50);
        chk("R3 addi X0", xr(0), 16'd13);
        chk("R3 addi X1", xr(1), 16'd2);
        chk("R2 add fn3 ignored", xr(2), 16'd15);
        chk("R2 sub", xr(3), 16'd11);
        chk("R2 shl", xr(4), 16'd52);
        chk("R2 slt true", xr(5), 16'd1);
        chk("R2 and", xr(6), 16'd0);
        chk("R9 halt pc", dbg_pc, 16'd7);
    endtask

    task automatic t_reset();
        clear_prog();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 pc cleared", dbg_pc, 16'd0);
        chk("R1 halted cleared", 16'(halted), 16'd0);
        for (int i = 0; i < 8; i++) chk("R1 reg cleared", xr(i), 16'd0);
    endtask

    task automatic t_alu_b();
        clear_prog();
        prog[0] = i_ins(3'b001, 0, 7, 13);
        prog[1] = i_ins(3'b001, 1, 7, 2);
        prog[2] = r_ins(2, 0, 1, 4'b0101);
        prog[3] = r_ins(3, 0, 1, 4'b0110);
        prog[4] = r_ins(4, 0, 1, 4'b0111);
        prog[5] = i_ins(3'b010, 5, 1, 3);
        prog[6] = i_ins(3'b001, 6, 7, -64);
        prog[7] = r_ins(0, 5, 1, 4'b0011);
        prog[8] = r_ins(1, 0, 6, 4'b0011);
        load_and_start();
        run_to_halt("R10 alu_b halt", 50);
        chk("R2 or", xr(2), 16'd15);
        chk("R2 not", xr(3), 16'hFFF2);
        chk("R2 xor", xr(4), 16'd15);
        chk("R3 subi negative", xr(5), 16'hFFFF);
        chk("R3 sign extend", xr(6), 16'hFFC0);
        chk("R2 slt signed", xr(0), 16'd1);
        chk("R2 slt false", xr(1), 16'd0);
    endtask

    task automatic t_zero_reg();
        clear_prog();
        prog[0] = i_ins(3'b001, 7, 7, 5);
        prog[1] = r_ins(1, 7, 7, 4'b0000);
        prog[2] = r_ins(7, 7, 7, 4'b0110);
        load_and_start();
        run_to_halt("R10 zero halt", 20);
        chk("R8 X7 stays zero", xr(7), 16'd0);
        chk("R8 X7 reads zero", xr(1), 16'd0);
    endtask

    task automatic t_memory();
        clear_prog();
        prog[0] = i_ins(3'b001, 2, 7, 10);
        prog[1] = i_ins(3'b001, 0, 7, 3);
        prog[2] = i_ins(3'b001, 1, 7, 5);
        prog[3] = i_ins(3'b011, 0, 2, 0);
        prog[4] = i_ins(3'b011, 1, 2, 1);
        prog[5] = i_ins(3'b100, 3, 2, 0);
        prog[6] = i_ins(3'b100, 4, 2, 1);
        prog[7] = i_ins(3'b001, 5, 7, -1);
        prog[8] = i_ins(3'b011, 1, 5, 0);    // address 0xFFFF -> word 255
        prog[9] = i_ins(3'b100, 6, 7, -1);
        load_and_start();
        run_to_halt("R10 mem halt", 50);
        chk("R5 load word 10", xr(3), 16'd3);
        chk("R5 load word 11", xr(4), 16'd5);
        chk("R4 store no reg write", xr(2), 16'd10);
        chk("R4 store no reg write rt", xr(1), 16'd5);
        chk("R5 address wrap", xr(6), 16'd5);
        chk("R11 program loaded", dbg_pc, 16'd10);
    endtask

    task automatic t_flow();
        logic [127:0] snap;
        clear_prog();
        prog[0]  = i_ins(3'b001, 0, 7, 3);
        prog[1]  = i_ins(3'b001, 1, 7, 5);
        prog[2]  = j_ins(5);
        prog[3]  = i_ins(3'b001, 0, 7, 9);
        prog[5]  = i_ins(3'b110, 0, 0, 8);
        prog[6]  = i_ins(3'b001, 1, 7, 9);
        prog[8]  = i_ins(3'b110, 1, 0, 11);
        prog[9]  = i_ins(3'b001, 2, 7, 7);
        prog[11] = i_ins(3'b001, 3, 7, 1);
        load_and_start();
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R7 jump target", dbg_pc, 16'd5);
        @(negedge clk);
        chk("R6 branch taken", dbg_pc, 16'd8);
        @(negedge clk);
        chk("R6 branch not taken", dbg_pc, 16'd9);
        run_to_halt("R10 flow halt", 20);
        chk("R7 jump skipped", xr(0), 16'd3);
        chk("R6 taken skipped", xr(1), 16'd5);
        chk("R6 fallthrough", xr(2), 16'd7);
        chk("R6 target not reached", xr(3), 16'd0);
        chk("R10 halt pc", dbg_pc, 16'd10);
        snap = dbg_regs;
        repeat (10) @(negedge clk);
        chk("R10 pc frozen", dbg_pc, 16'd10);
        chk("R10 still halted", 16'(halted), 16'd1);
        chk("R10 regs frozen", 16'(dbg_regs == snap), 16'd1);
    endtask

    task automatic t_halt_first();
        clear_prog();
        prog[1] = i_ins(3'b001, 1, 7, 4);
        load_and_start();
        chk("R10 not halted before edge", 16'(halted), 16'd0);
        @(negedge clk);
        chk("R10 halted after edge", 16'(halted), 16'd1);
        repeat (3) @(negedge clk);
        chk("R10 pc held at 0", dbg_pc, 16'd0);
        chk("R10 no write", xr(1), 16'd0);
    endtask

    task automatic t_noop();
        clear_prog();
        prog[0] = 16'hE123;
        prog[1] = i_ins(3'b001, 1, 7, 4);
        load_and_start();
        @(negedge clk);
        chk("R12 ext opcode advances", dbg_pc, 16'd1);
        chk("R12 ext opcode not halted", 16'(halted), 16'd0);
        chk("R12 ext opcode no write", xr(1), 16'd0);
        run_to_halt("R12 noop halt", 20);
        chk("R12 after noop", xr(1), 16'd4);
        chk("R9 pc after noop", dbg_pc, 16'd2);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        t_alu_a();
        t_reset();
        t_alu_b();
        t_zero_reg();
        t_memory();
        t_flow();
        t_halt_first();
        t_noop();
        finish_run();
    end
endmodule